// File: doc/BRIEF.md
# Fractional-N Dual-Modulus Divider Controller

This block is the digital core of a fractional-N feedback divider. It runs on the output clock of a 32/33 dual-modulus prescaler, so each of its clock cycles is one prescaler period. It drives the prescaler's modulus-control line and counts prescaler periods, so that one divider cycle spans exactly N cycles of the oscillator clock. At the end of each divider cycle it issues a one-cycle pulse for the phase detector.

A modulo-FMOD accumulator adds the fractional increment NF once per divider cycle. Each time the accumulator wraps, the following divider cycle is stretched to N+1. Over FMOD cycles the mean ratio is therefore N + NF/FMOD. The accumulator value is brought out to scale a sideband compensation source. The wrap flag is brought out for test observation.

A new N, NF and FMOD can be requested at any time. The request is held and takes effect only at the next divider-cycle boundary, so the divider never jumps phase part-way through a cycle.

Top module: `fracn_div_ctrl`

## Requirements
- R1: The active ratio splits into a swallow count A (ratio bits 4:0) and a main count B (ratio bits 17:5). A divider cycle lasts exactly B prescaler cycles.
- R2: `mod_ctrl` (1 = divide by 33, 0 = divide by 32) is high for the first A prescaler cycles of a divider cycle and low for the rest. The oscillator ratio is therefore 33·A + 32·(B−A), which equals the active ratio.
- R3: `div_pulse` is high for exactly the last prescaler cycle of each divider cycle. `sync` is low in that cycle and high in every other cycle.
- R4: At every divider-cycle boundary without a configuration change, the accumulator becomes (acc + NF) mod FMOD. `acc_val` holds the accumulator's value for the whole divider cycle.
- R5: When the addition at a boundary reaches FMOD or more, the next divider cycle uses ratio N+1. `acc_ovf` is high throughout that stretched cycle and low during an unstretched cycle.
- R6: With NF = 0, the accumulator stays at 0 and no cycle is stretched.
- R7: The +1 stretch is added to the whole ratio, so a swallow count of 31 carries into the main count (for example, 2047 becomes A = 0 and B = 64).
- R8: A `cfg_load` pulse is captured and applied only at the next divider-cycle boundary. The cycle in progress completes with the old ratio. On application, the accumulator clears to 0 and the first new cycle is not stretched.
- R9: After reset, `acc_val` = 0, `acc_ovf` = 0, `sync` = 1 and `div_pulse` = 0. The first divider cycle uses the ratio parameter RST_N (992 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Request to adopt cfg_n, cfg_nf and cfg_fmod |
| cfg_n | input | 18 | Integer ratio N (992 to 262143) |
| cfg_nf | input | 4 | Fractional increment NF (below FMOD) |
| cfg_fmod | input | 5 | Accumulator modulus FMOD (1 to 16) |
| mod_ctrl | output | 1 | Prescaler modulus select: 1 = divide by 33 |
| div_pulse | output | 1 | Divider output pulse for the phase detector |
| sync | output | 1 | High while the divider counts, low at terminal count |
| acc_val | output | 5 | Accumulator value for compensation |
| acc_ovf | output | 1 | High during a cycle stretched to N+1 |

## Verification
The main function is exercised with six settings:
- A 3/8 fraction, which reproduces the known 3,6,1,4,7,2,5,0 accumulator pattern.
- An integer channel (NF = 0), which shows that no stretch occurs.
- A ratio of 2047 with a stretch, which separates a correct carry into B from a stretch that wraps inside A.
- Modulus 16 with NF = 15, which checks the widest accumulator and a stretch on almost every cycle.
- A ratio at the top of the range, which checks the main-count width.
- A ratio at the minimum of 992, with A = 0, which shows that `mod_ctrl` can stay low for the whole cycle.

Each cycle's length and number of divide-by-33 periods are measured at the ports and converted into an oscillator count. This count reveals a wrong split between A and B as well as a misplaced stretch. A load issued part-way through a cycle shows whether the update is deferred to the boundary or applied at once.

// File: rtl/fdc_pkg.sv
package fdc_pkg;
   // default geometry of a 32/33 prescaler with an 18-bit ratio
   localparam int FDC_N_W  = 18;
   localparam int FDC_A_W  = 5;
   localparam int FDC_NF_W = 4;
   localparam int FDC_FM_W = 5;

   // smallest ratio for which every swallow count fits inside the main count
   function automatic int fdc_min_ratio(input int a_w);
      return ((1 << a_w) - 1) * (1 << a_w);
   endfunction
endpackage

// File: rtl/fdc_swallow.sv
module fdc_swallow #(
   parameter int N_W   = 18,
   parameter int A_W   = 5,
   parameter int RST_N = 992
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [N_W-1:0] ratio_nxt,
   output logic           mc_o,
   output logic           term_o
);
   localparam int B_W = N_W - A_W;
   localparam logic [N_W-1:0] RST_V = N_W'(RST_N);

   initial begin
      assert (B_W > A_W) else $error("main count must be wider than swallow count");
   end

   logic [A_W-1:0] a_q;
   logic [B_W-1:0] b_q;
   logic [B_W-1:0] cnt_q;

   assign term_o = (cnt_q == b_q - B_W'(1));
   assign mc_o   = (B_W'(a_q) > cnt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         a_q   <= RST_V[A_W-1:0];
         b_q   <= RST_V[N_W-1:A_W];
      end else if (term_o) begin
         cnt_q <= '0;
         a_q   <= ratio_nxt[A_W-1:0];
         b_q   <= ratio_nxt[N_W-1:A_W];
      end else begin
         cnt_q <= cnt_q + B_W'(1);
      end
   end

   // R2
   mc_contiguous_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mc_o && !term_o) |=> !mc_o);
endmodule

// File: rtl/fdc_accum.sv
module fdc_accum #(
   parameter int NF_W = 4,
   parameter int FM_W = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            step,
   input  logic            clear,
   input  logic [NF_W-1:0] nf_i,
   input  logic [FM_W-1:0] fmod_i,
   output logic [FM_W-1:0] acc_o,
   output logic            carry_o
);
   localparam int S_W = FM_W + 1;

   initial begin
      assert (NF_W <= FM_W) else $error("increment wider than modulus");
   end

   logic [FM_W-1:0] acc_q;
   logic [S_W-1:0]  sum_w;
   logic [S_W-1:0]  nxt_w;

   assign sum_w   = {1'b0, acc_q} + S_W'(nf_i);
   assign carry_o = (sum_w >= {1'b0, fmod_i});
   assign nxt_w   = carry_o ? (sum_w - {1'b0, fmod_i}) : sum_w;
   assign acc_o   = acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     acc_q <= '0;
      else if (clear) acc_q <= '0;
      else if (step)  acc_q <= nxt_w[FM_W-1:0];
   end

   // R4
   acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_q < fmod_i);
   // R6
   acc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (nf_i == '0 && acc_q == '0) |=> acc_q == '0);
endmodule

// File: rtl/fracn_div_ctrl.sv
module fracn_div_ctrl
   import fdc_pkg::*;
#(
   parameter int N_W       = FDC_N_W,
   parameter int A_W       = FDC_A_W,
   parameter int NF_W      = FDC_NF_W,
   parameter int FM_W      = FDC_FM_W,
   parameter int RST_N     = 992,
   parameter bit PULSE_REG = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_load,
   input  logic [N_W-1:0]  cfg_n,
   input  logic [NF_W-1:0] cfg_nf,
   input  logic [FM_W-1:0] cfg_fmod,
   output logic            mod_ctrl,
   output logic            div_pulse,
   output logic            sync,
   output logic [FM_W-1:0] acc_val,
   output logic            acc_ovf
);
   initial begin
      assert (RST_N >= fdc_min_ratio(A_W)) else $error("reset ratio below range");
      assert (RST_N < (1 << N_W)) else $error("reset ratio exceeds width");
   end

   logic [N_W-1:0]  act_n_q,  pn_q;
   logic [NF_W-1:0] act_nf_q, pnf_q;
   logic [FM_W-1:0] act_fm_q, pfm_q;
   logic            pend_q, ovf_q;
   logic            term_w, carry_w, apply_w;
   logic [N_W-1:0]  ratio_nxt;

   assign apply_w   = term_w & pend_q;
   assign ratio_nxt = apply_w ? pn_q : (act_n_q + N_W'(carry_w));
   assign acc_ovf   = ovf_q;

   // pending configuration, adopted only at a boundary
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         pn_q   <= '0;
         pnf_q  <= '0;
         pfm_q  <= FM_W'(1);
      end else if (cfg_load) begin
         pend_q <= 1'b1;
         pn_q   <= cfg_n;
         pnf_q  <= cfg_nf;
         pfm_q  <= cfg_fmod;
      end else if (apply_w) begin
         pend_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_n_q  <= N_W'(RST_N);
         act_nf_q <= '0;
         act_fm_q <= FM_W'(1);
         ovf_q    <= 1'b0;
      end else if (term_w) begin
         ovf_q <= !pend_q && carry_w;
         if (pend_q) begin
            act_n_q  <= pn_q;
            act_nf_q <= pnf_q;
            act_fm_q <= pfm_q;
         end
      end
   end

   fdc_swallow #(.N_W(N_W), .A_W(A_W), .RST_N(RST_N)) u_cnt (
      .clk(clk), .rst_n(rst_n), .ratio_nxt(ratio_nxt),
      .mc_o(mod_ctrl), .term_o(term_w));

   fdc_accum #(.NF_W(NF_W), .FM_W(FM_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .step(term_w & !pend_q), .clear(apply_w),
      .nf_i(act_nf_q), .fmod_i(act_fm_q), .acc_o(acc_val), .carry_o(carry_w));

   generate
      if (PULSE_REG) begin : g_pulse_reg
         logic pulse_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pulse_q <= 1'b0;
            else        pulse_q <= term_w;
         end
         assign div_pulse = pulse_q;
      end else begin : g_pulse_comb
         assign div_pulse = term_w;
      end
   endgenerate
   assign sync = !div_pulse;

   // R3
   pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div_pulse |=> !div_pulse);
   // R8
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !term_w |=> $stable(act_n_q) && $stable(act_fm_q));
endmodule

// File: tb/tb_fracn_div_ctrl.sv
`timescale 1ns/1ps
module tb_fracn_div_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_load = 1'b0;
   logic [17:0] cfg_n = '0;
   logic [3:0]  cfg_nf = '0;
   logic [4:0]  cfg_fmod = 5'd1;
   logic        mod_ctrl, div_pulse, sync, acc_ovf;
   logic [4:0]  acc_val;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   fracn_div_ctrl dut (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_n(cfg_n),
      .cfg_nf(cfg_nf), .cfg_fmod(cfg_fmod), .mod_ctrl(mod_ctrl),
      .div_pulse(div_pulse), .sync(sync), .acc_val(acc_val), .acc_ovf(acc_ovf));

   // stimulus table: ratio, increment, modulus
   localparam int NV = 6;
   localparam int V_N  [NV] = '{1000, 992, 2047, 4000, 262142, 1234};
   localparam int V_NF [NV] = '{3,    0,   6,    5,    1,      15};
   localparam int V_FM [NV] = '{8,    1,   8,    16,   3,      16};

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // called at the first negedge of a divider cycle; returns at the next one
   task automatic measure(output int len, output int mcs, output int a0,
                          output int o0, output bit shape_ok);
      bit fell = 1'b0;
      len = 0; mcs = 0; shape_ok = 1'b1;
      a0 = acc_val; o0 = acc_ovf;
      forever begin
         len++;
         if (mod_ctrl) begin
            mcs++;
            if (fell) shape_ok = 1'b0;
         end else fell = 1'b1;
         if (sync == div_pulse) shape_ok = 1'b0;
         if (acc_val != a0 || acc_ovf != o0) shape_ok = 1'b0;
         if (div_pulse) break;
         @(negedge clk);
      end
      @(negedge clk);
   endtask

   task automatic load_cfg(input int n, input int nf, input int fm);
      cfg_n = 18'(n); cfg_nf = 4'(nf); cfg_fmod = 5'(fm); cfg_load = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0;
      while (!div_pulse) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(64'd4_000_000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         report();
      end
   end

   initial begin
      int len, mcs, a0, o0, macc, s, sum, expr;
      bit shp;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R9 reset state, sampled before the first active edge
      chk(sync == 1'b1 && div_pulse == 1'b0, "R9 sync/pulse", {sync, div_pulse}, 2);
      chk(acc_val == 0 && acc_ovf == 0, "R9 acc", {acc_val, acc_ovf}, 0);
      measure(len, mcs, a0, o0, shp);
      chk(33*mcs + 32*(len-mcs) == 992, "R9 first ratio", 33*mcs + 32*(len-mcs), 992);
      chk(mcs == 0 && shp, "R2 A=0 keeps mod_ctrl low", mcs, 0);

      for (int v = 0; v < NV; v++) begin
         load_cfg(V_N[v], V_NF[v], V_FM[v]);
         macc = 0; s = 0;
         for (int k = 0; k <= V_FM[v]; k++) begin
            measure(len, mcs, a0, o0, shp);
            expr = V_N[v] + s;
            chk(len == (expr >> 5), "R1 main count", len, expr >> 5);
            chk(mcs == (expr & 31), "R2/R7 swallow count", mcs, expr & 31);
            chk(33*mcs + 32*(len-mcs) == expr, "R2 vco ratio", 33*mcs + 32*(len-mcs), expr);
            chk(shp, "R3 pulse/sync shape", 0, 1);
            chk(a0 == macc, (V_NF[v] == 0) ? "R6 acc idle" : "R4 acc value", a0, macc);
            chk(o0 == s, "R5 stretch flag", o0, s);
            sum = macc + V_NF[v];
            s = (sum >= V_FM[v]) ? 1 : 0;
            macc = s ? sum - V_FM[v] : sum;
         end
      end

      // R8: load mid-cycle, running cycle keeps old ratio, next adopts new
      load_cfg(1500, 0, 1);
      len = 0; mcs = 0;
      forever begin
         len++;
         if (mod_ctrl) mcs++;
         if (len == 6) begin
            cfg_n = 18'd2000; cfg_nf = 4'd0; cfg_fmod = 5'd1; cfg_load = 1'b1;
         end else cfg_load = 1'b0;
         if (div_pulse) break;
         @(negedge clk);
      end
      @(negedge clk);
      chk(33*mcs + 32*(len-mcs) == 1500, "R8 deferred load",
          33*mcs + 32*(len-mcs), 1500);
      measure(len, mcs, a0, o0, shp);
      chk(33*mcs + 32*(len-mcs) == 2000, "R8 applied at boundary",
          33*mcs + 32*(len-mcs), 2000);

      // R8: applying a config clears a non-zero accumulator
      load_cfg(1100, 7, 9);
      repeat (3) measure(len, mcs, a0, o0, shp);
      chk(a0 != 0, "R4 acc nonzero before reload", a0, 3);
      load_cfg(1200, 2, 5);
      measure(len, mcs, a0, o0, shp);
      chk(a0 == 0 && o0 == 0, "R8 acc cleared", a0, 0);
      chk(33*mcs + 32*(len-mcs) == 1200, "R8 first cycle unstretched",
          33*mcs + 32*(len-mcs), 1200);

      done = 1'b1;
      report();
   end
endmodule